// File: doc/BRIEF.md
# Single-Level Page Table Walker

This block turns a virtual address into a physical address with one lookup in a flat page table held in memory. The requester presents a virtual address and the base address of the table. The block splits the virtual address into a page number and a 12-bit in-page offset. It forms the entry address as the base plus four times the page number and issues one read on a request/response memory port. It then waits for the memory to answer.

When the entry arrives, the block checks the entry's valid flag. A valid entry gives a one-cycle done pulse. With that pulse come the physical address and the entry's three permission bits. The physical address is the entry's frame number joined to the offset, which passes through unchanged. An entry whose valid flag is clear gives a one-cycle fault pulse and no address. The block handles one walk at a time. It takes a new request only while it is idle.

Top module: `pt_walker`

## Requirements
- R1: After reset the block is idle: `req_ready_o` is 1, and `mem_rd_valid_o`, `done_o` and `fault_o` are all 0.
- R2: A request (`req_valid_i` high) is taken only in a cycle where `req_ready_o` is 1. `req_ready_o` is low from the cycle after acceptance until the result pulse. Requests presented while busy have no effect on the read address or on the result of the walk in progress.
- R3: The read address is the request's base plus `vaddr[31:12]` shifted left by two, taken modulo 2^32. It appears on `mem_rd_addr_o` with `mem_rd_valid_o` in the cycle after acceptance.
- R4: `mem_rd_valid_o` and `mem_rd_addr_o` stay unchanged until the clock edge at which `mem_rsp_valid_i` is sampled high. No result pulse appears before that edge.
- R5: An entry with bit 0 (valid) set gives `done_o` high for exactly the cycle after the response edge. In that cycle `paddr_o` equals {entry[31:12], vaddr[11:0]}.
- R6: An entry with bit 0 clear gives `fault_o` high for exactly the cycle after the response edge. In that cycle `done_o` stays 0 and `paddr_o` is 0.
- R7: With `done_o`, `perm_o` carries entry bits 3:1, in the order read, write, execute from bit 2 down to bit 0.
- R8: `done_o` and `fault_o` are never high together. Each lasts one cycle. `req_ready_o` is already high in the pulse cycle.
- R9: With base 0x1000 and an entry for page 3 holding frame 7, the virtual addresses 0x3000, 0x3004 and 0x3008 each read 0x100C. They translate to 0x7000, 0x7004 and 0x7008.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Translation request strobe |
| req_vaddr_i | input | 32 | Virtual address to translate |
| req_base_i | input | 32 | Page-table base address |
| req_ready_o | output | 1 | Block is idle and takes a request |
| mem_rd_valid_o | output | 1 | Entry read outstanding |
| mem_rd_addr_o | output | 32 | Byte address of the entry |
| mem_rsp_valid_i | input | 1 | Memory response strobe |
| mem_rsp_data_i | input | 32 | Returned page table entry |
| done_o | output | 1 | Translation succeeded (one cycle) |
| fault_o | output | 1 | Entry invalid (one cycle) |
| paddr_o | output | 32 | Physical address, valid with done_o |
| perm_o | output | 3 | Permission bits of the entry, valid with done_o |

## Verification
The bench targets each point where a walk could go wrong. It varies the memory response delay, including a response in the first cycle of the read; a design that latched the entry early or late would report a stale frame. It drives requests while a walk is busy; a design that accepted them would change the read address or the result. It uses entries with the valid bit clear; a design that ignored the flag would pulse done with a bogus address. A base near the top of the address space checks that the entry address wraps modulo 2^32 rather than picking up bits beyond that range. Runs of addresses within one page check that the offset passes through and the same entry address is reused.

// File: rtl/pt_walk_pkg.sv
package pt_walk_pkg;
  typedef enum logic [0:0] {
    WALK_IDLE = 1'b0,
    WALK_READ = 1'b1
  } walk_state_e;

  localparam int unsigned PTE_VALID_BIT = 0;
  localparam int unsigned PTE_PERM_LSB  = 1;
  localparam int unsigned PTE_PERM_W    = 3;
endpackage

// File: rtl/pt_addr_gen.sv
module pt_addr_gen #(
  parameter int unsigned VA_W     = 32,
  parameter int unsigned PA_W     = 32,
  parameter int unsigned OFF_W    = 12,
  parameter int unsigned PTE_LOG2 = 2
) (
  input  logic [VA_W-1:0]  vaddr_i,
  input  logic [PA_W-1:0]  base_i,
  output logic [PA_W-1:0]  pte_addr_o,
  output logic [OFF_W-1:0] offset_o
);
  localparam int unsigned VPN_W = VA_W - OFF_W;

  logic [VPN_W-1:0] vpn;
  logic [PA_W-1:0]  index_bytes;

  always_comb begin
    vpn         = vaddr_i[VA_W-1:OFF_W];
    offset_o    = vaddr_i[OFF_W-1:0];
    index_bytes = PA_W'(vpn) << PTE_LOG2;
    pte_addr_o  = base_i + index_bytes;
  end
endmodule

// File: rtl/pt_pte_decode.sv
module pt_pte_decode
  import pt_walk_pkg::*;
#(
  parameter int unsigned PTE_W   = 32,
  parameter int unsigned OFF_W   = 12,
  localparam int unsigned FRAME_W = PTE_W - OFF_W
) (
  input  logic [PTE_W-1:0]      pte_i,
  output logic                  valid_o,
  output logic [PTE_PERM_W-1:0] perm_o,
  output logic [FRAME_W-1:0]    frame_o
);
  always_comb begin
    valid_o = pte_i[PTE_VALID_BIT];
    perm_o  = pte_i[PTE_PERM_LSB +: PTE_PERM_W];
    frame_o = pte_i[PTE_W-1:OFF_W];
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walk_pkg::*;
#(
  parameter int unsigned VA_W     = 32,
  parameter int unsigned PTE_W    = 32,
  parameter int unsigned OFF_W    = 12,
  parameter int unsigned PTE_LOG2 = 2,
  localparam int unsigned FRAME_W = PTE_W - OFF_W,
  localparam int unsigned PA_W    = FRAME_W + OFF_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid_i,
  input  logic [VA_W-1:0]       req_vaddr_i,
  input  logic [PA_W-1:0]       req_base_i,
  output logic                  req_ready_o,
  output logic                  mem_rd_valid_o,
  output logic [PA_W-1:0]       mem_rd_addr_o,
  input  logic                  mem_rsp_valid_i,
  input  logic [PTE_W-1:0]      mem_rsp_data_i,
  output logic                  done_o,
  output logic                  fault_o,
  output logic [PA_W-1:0]       paddr_o,
  output logic [PTE_PERM_W-1:0] perm_o
);
  walk_state_e state_q, state_d;

  logic [PA_W-1:0]       pte_addr_c;
  logic [OFF_W-1:0]      offset_c;
  logic                  ent_valid_c;
  logic [PTE_PERM_W-1:0] ent_perm_c;
  logic [FRAME_W-1:0]    ent_frame_c;

  logic [PA_W-1:0]       rd_addr_q;
  logic [OFF_W-1:0]      off_q;
  logic                  done_q, fault_q, done_d, fault_d;
  logic [PA_W-1:0]       paddr_q, paddr_d;
  logic [PTE_PERM_W-1:0] perm_q, perm_d;

  logic accept_en, resp_en, res_en;

  pt_addr_gen #(
    .VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W), .PTE_LOG2(PTE_LOG2)
  ) u_addr (
    .vaddr_i(req_vaddr_i), .base_i(req_base_i),
    .pte_addr_o(pte_addr_c), .offset_o(offset_c)
  );

  pt_pte_decode #(.PTE_W(PTE_W), .OFF_W(OFF_W)) u_dec (
    .pte_i(mem_rsp_data_i), .valid_o(ent_valid_c),
    .perm_o(ent_perm_c), .frame_o(ent_frame_c)
  );

  // next-state and result logic
  always_comb begin
    accept_en = (state_q == WALK_IDLE) && req_valid_i;
    resp_en   = (state_q == WALK_READ) && mem_rsp_valid_i;
    state_d   = state_q;
    if (accept_en) state_d = WALK_READ;
    if (resp_en)   state_d = WALK_IDLE;

    done_d  = resp_en && ent_valid_c;
    fault_d = resp_en && !ent_valid_c;
    res_en  = resp_en;
    paddr_d = ent_valid_c ? {ent_frame_c, off_q} : '0;
    perm_d  = ent_valid_c ? ent_perm_c : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WALK_IDLE;
      done_q  <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      fault_q <= fault_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_addr_q <= '0;
      off_q     <= '0;
    end else if (accept_en) begin
      rd_addr_q <= pte_addr_c;
      off_q     <= offset_c;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      paddr_q <= '0;
      perm_q  <= '0;
    end else if (res_en) begin
      paddr_q <= paddr_d;
      perm_q  <= perm_d;
    end
  end

  assign req_ready_o    = (state_q == WALK_IDLE);
  assign mem_rd_valid_o = (state_q == WALK_READ);
  assign mem_rd_addr_o  = rd_addr_q;
  assign done_o         = done_q;
  assign fault_o        = fault_q;
  assign paddr_o        = paddr_q;
  assign perm_o         = perm_q;
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int unsigned PA_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid_i,
  input logic            req_ready_o,
  input logic            mem_rd_valid_o,
  input logic [PA_W-1:0] mem_rd_addr_o,
  input logic            mem_rsp_valid_i,
  input logic            done_o,
  input logic            fault_o,
  input logic [PA_W-1:0] paddr_o
);
  assert_ready_no_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready_o |-> !mem_rd_valid_o);

  assert_accept_reads_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && req_ready_o) |=> mem_rd_valid_o);

  assert_addr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid_o && !mem_rsp_valid_i) |=> (mem_rd_valid_o && $stable(mem_rd_addr_o)));

  assert_result_after_rsp_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o || fault_o) |-> $past(mem_rd_valid_o && mem_rsp_valid_i));

  assert_fault_no_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> (paddr_o == '0));

  assert_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && fault_o));

  assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o || fault_o) |=> !(done_o || fault_o));

  assert_idle_on_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o || fault_o) |-> req_ready_o);
endmodule

bind pt_walker pt_walker_chk #(.PA_W(PA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
  .mem_rd_valid_o(mem_rd_valid_o), .mem_rd_addr_o(mem_rd_addr_o),
  .mem_rsp_valid_i(mem_rsp_valid_i), .done_o(done_o), .fault_o(fault_o),
  .paddr_o(paddr_o)
);

// File: tb/tb_pt_walker.sv
module tb_pt_walker;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid_i;
  logic [31:0] req_vaddr_i, req_base_i;
  logic        req_ready_o, mem_rd_valid_o;
  logic [31:0] mem_rd_addr_o;
  logic        mem_rsp_valid_i;
  logic [31:0] mem_rsp_data_i;
  logic        done_o, fault_o;
  logic [31:0] paddr_o;
  logic [2:0]  perm_o;

  int n_cmp = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  pt_walker dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd_addr(input logic [31:0] va, input logic [31:0] base);
    return base + {va[31:12], 2'b00};
  endfunction

  function automatic logic [31:0] exp_paddr(input logic [31:0] va, input logic [31:0] pte);
    return pte[0] ? {pte[31:12], va[11:0]} : 32'h0;
  endfunction

  task automatic walk(input logic [31:0] va, input logic [31:0] base,
                      input logic [31:0] pte, input int delay, input bit stray);
    logic [31:0] ea;
    ea = exp_rd_addr(va, base);
    @(negedge clk);
    chk("R2 ready before request", {31'd0, req_ready_o}, 32'd1);
    req_valid_i = 1'b1; req_vaddr_i = va; req_base_i = base;
    @(negedge clk);
    req_valid_i = 1'b0;
    chk("R2 ready low while busy", {31'd0, req_ready_o}, 32'd0);
    chk("R3 read valid", {31'd0, mem_rd_valid_o}, 32'd1);
    chk("R3 read address", mem_rd_addr_o, ea);
    for (int i = 0; i < delay; i++) begin
      if (stray) begin
        req_valid_i = 1'b1; req_vaddr_i = $urandom; req_base_i = $urandom;
      end
      @(negedge clk);
      req_valid_i = 1'b0;
      chk("R4 read held", {31'd0, mem_rd_valid_o}, 32'd1);
      chk("R4 address held / R2 stray ignored", mem_rd_addr_o, ea);
      chk("R4 no early result", {30'd0, done_o, fault_o}, 32'd0);
    end
    mem_rsp_valid_i = 1'b1; mem_rsp_data_i = pte;
    @(negedge clk);
    mem_rsp_valid_i = 1'b0; mem_rsp_data_i = $urandom;
    if (pte[0]) begin
      chk("R5 done pulse", {30'd0, done_o, fault_o}, 32'b10);
      chk("R5 physical address", paddr_o, exp_paddr(va, pte));
      chk("R7 permissions", {29'd0, perm_o}, {29'd0, pte[3:1]});
    end else begin
      chk("R6 fault pulse", {30'd0, done_o, fault_o}, 32'b01);
      chk("R6 no address", paddr_o, 32'h0);
    end
    chk("R8 ready with pulse", {31'd0, req_ready_o}, 32'd1);
    @(negedge clk);
    chk("R8 pulse is one cycle", {30'd0, done_o, fault_o}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd537));
    rst_n = 1'b0; req_valid_i = 1'b0; req_vaddr_i = '0; req_base_i = '0;
    mem_rsp_valid_i = 1'b0; mem_rsp_data_i = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset ready", {31'd0, req_ready_o}, 32'd1);
    chk("R1 reset outputs", {29'd0, mem_rd_valid_o, done_o, fault_o}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after release", {31'd0, req_ready_o}, 32'd1);

    // R9 directed: same page, same entry address
    walk(32'h0000_3000, 32'h0000_1000, 32'h0000_700F, 0, 0);
    walk(32'h0000_3004, 32'h0000_1000, 32'h0000_700F, 2, 1);
    walk(32'h0000_3008, 32'h0000_1000, 32'h0000_700F, 1, 0);
    chk("R9 example translation", exp_paddr(32'h3008, 32'h700F), 32'h7008);
    // R6 invalid entry, with permission bits set
    walk(32'h0000_3000, 32'h0000_1000, 32'h0000_700E, 3, 1);
    // R3 wraparound near top of address space
    walk(32'hFFFF_FABC, 32'hFFFF_F000, 32'hABCD_E00B, 0, 0);
    // R5 offset all ones, frame all ones
    walk(32'h0000_0FFF, 32'h0000_0000, 32'hFFFF_F001, 4, 1);

    for (int k = 0; k < 300; k++) begin
      logic [31:0] va, base, pte;
      va = $urandom; base = $urandom; pte = $urandom;
      pte[0] = ($urandom_range(0, 4) != 0);
      walk(va, base, pte, $urandom_range(0, 4), $urandom_range(0, 1) == 1);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule